// File: doc/BRIEF.md
# Asynchronous static memory timing sequencer

This block converts a single internal read or write request into a timed access on an external asynchronous static memory or NOR-type bus. The access has three phases. An address setup phase comes first. An address hold phase follows, but only when the bus is multiplexed. The data phase comes last. Each phase length is a whole number of system clock cycles, taken from a 16-bit timing register that software writes. The block drives these outputs: an active-low chip select, an active-low output enable, an active-low write enable, an active-low address valid strobe, a separate address bus, and a shared address/data bus with its own drive enable. When the access ends, it raises a one-cycle done pulse, and read data is available at that point.

A request is accepted only while the block is idle. The timing register contents, the multiplexing choice and the synchronous-mode choice are all latched when an access starts. A register write that happens during an access therefore takes effect on the next access. When synchronous mode is selected, the programmed fields are ignored and fixed minimum phase lengths are used instead.

Top module: `amseq_top`

## Requirements
- R1: After reset, the timing register reads as all ones (setup field 15, hold field 15, data field 255). Chip select, output enable, write enable and address valid are high, done is 0 and req_ready is 1.
- R2: The address setup phase lasts S+1 cycles, where S is the setup field in bits 3:0 (S may be 0). Address valid is low only during this phase. Chip select is low from the first setup cycle to the last data cycle.
- R3: On a multiplexed access (mux_en=1), an address hold phase follows setup and lasts H+1 cycles, where H is the field in bits 7:4. H=0 is treated as H=1. During setup and hold the shared bus drives the address.
- R4: On a non-multiplexed access (mux_en=0), the hold phase is skipped and the data phase follows setup directly.
- R5: The data phase lasts D+1 cycles, where D is the field in bits 15:8. D=0 is treated as D=1.
- R6: On a read, output enable is low for exactly the data phase, and the shared bus is not driven. rdata takes the value of mem_dq_in from the last data-phase cycle and holds it until the next read.
- R7: On a write, write enable is low for exactly the data phase. The shared bus drives the write data, with mem_dq_oe=1, through every cycle of that phase.
- R8: done is high for exactly one cycle, directly after the last data cycle, with chip select already high. req_ready is 1 only when idle, and a request raised during an access is never taken.
- R9: The timing fields, mux_en and sync_mode are latched when a request is accepted. A register write during an access changes only the accesses that follow it.
- R10: With sync_mode=1, the register fields are ignored and the phases last 1 cycle for setup, 2 cycles for hold (multiplexed only) and 2 cycles for data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_wdata | input | 16 | Timing register write value |
| cfg_rdata | output | 16 | Timing register contents |
| mux_en | input | 1 | 1 selects multiplexed address/data bus |
| sync_mode | input | 1 | 1 overrides fields with fixed minimum phases |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Idle, request will be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address valid strobe, active low |
| mem_addr | output | 16 | Address bus, held through the access |
| mem_dq_out | output | 16 | Shared bus outgoing value |
| mem_dq_oe | output | 1 | Shared bus drive enable |
| mem_dq_in | input | 16 | Shared bus incoming value |

## Verification
The bench sweeps every setup code from 0 to 15 and every hold code from 0 to 15. It runs a span of data codes, including 0 and 255, so that any off-by-one error or missing reserved-zero substitution shows up in the measured strobe widths. Multiplexed and non-multiplexed runs are compared to tell a skipped hold phase apart from one that is present. A changing bus pattern on reads shows whether capture happens on the last data cycle or an earlier one. Register writes and a stray request made during an access, together with synchronous-mode runs on extreme field values, show whether the settings are latched per access and whether the fields are really overridden.

// File: rtl/amseq_pkg.sv
package amseq_pkg;
    localparam int SET_W = 4;
    localparam int HLD_W = 4;
    localparam int DAT_W = 8;
    localparam int REG_W = SET_W + HLD_W + DAT_W;
    localparam int CNT_W = DAT_W;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_HOLD  = 3'd2,
        PH_DATA  = 3'd3,
        PH_DONE  = 3'd4
    } phase_e;

    typedef struct packed {
        logic [DAT_W-1:0] dat;
        logic [HLD_W-1:0] hld;
        logic [SET_W-1:0] set;
    } timing_t;
endpackage

// File: rtl/amseq_cfg_reg.sv
module amseq_cfg_reg
    import amseq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             sync_mode,
    output logic [REG_W-1:0] reg_out,
    output timing_t          eff
);
    timing_t reg_d, reg_q;

    always_comb begin
        reg_d = reg_q;
        if (wr_en) reg_d = timing_t'(wr_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '1;
        else        reg_q <= reg_d;
    end

    // Effective phase counts (length minus one); reserved zeros become one.
    always_comb begin
        eff = reg_q;
        if (reg_q.hld == '0) eff.hld = HLD_W'(1);
        if (reg_q.dat == '0) eff.dat = DAT_W'(1);
        if (sync_mode) begin
            eff.set = '0;
            eff.hld = HLD_W'(1);
            eff.dat = DAT_W'(1);
        end
    end

    assign reg_out = reg_q;
endmodule

// File: rtl/amseq_strobe.sv
module amseq_strobe
    import amseq_pkg::*;
(
    input  phase_e phase,
    input  logic   is_write,
    input  logic   is_mux,
    output logic   cs_n,
    output logic   oe_n,
    output logic   we_n,
    output logic   adv_n,
    output logic   dq_oe,
    output logic   dq_addr
);
    always_comb begin
        cs_n    = 1'b1;
        oe_n    = 1'b1;
        we_n    = 1'b1;
        adv_n   = 1'b1;
        dq_oe   = 1'b0;
        dq_addr = 1'b0;
        unique case (phase)
            PH_SETUP: begin
                cs_n    = 1'b0;
                adv_n   = 1'b0;
                dq_oe   = is_mux;
                dq_addr = 1'b1;
            end
            PH_HOLD: begin
                cs_n    = 1'b0;
                dq_oe   = is_mux;
                dq_addr = 1'b1;
            end
            PH_DATA: begin
                cs_n  = 1'b0;
                oe_n  = is_write;
                we_n  = !is_write;
                dq_oe = is_write;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/amseq_top.sv
module amseq_top
    import amseq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              mux_en,
    input  logic              sync_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_adv_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic              mux;
        timing_t           tim;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t  s_d, s_q;
    timing_t eff;
    logic    dq_addr;

    amseq_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_data   (cfg_wdata),
        .sync_mode (sync_mode),
        .reg_out   (cfg_rdata),
        .eff       (eff)
    );

    amseq_strobe u_strobe (
        .phase    (s_q.phase),
        .is_write (s_q.wr),
        .is_mux   (s_q.mux),
        .cs_n     (mem_cs_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .adv_n    (mem_adv_n),
        .dq_oe    (mem_dq_oe),
        .dq_addr  (dq_addr)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.phase = PH_SETUP;
                    s_d.cnt   = CNT_W'(eff.set);
                    s_d.tim   = eff;
                    s_d.wr    = req_write;
                    s_d.mux   = mux_en;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else if (s_q.mux) begin
                    s_d.phase = PH_HOLD;
                    s_d.cnt   = CNT_W'(s_q.tim.hld);
                end else begin
                    s_d.phase = PH_DATA;
                    s_d.cnt   = CNT_W'(s_q.tim.dat);
                end
            end
            PH_HOLD: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    s_d.phase = PH_DATA;
                    s_d.cnt   = CNT_W'(s_q.tim.dat);
                end
            end
            PH_DATA: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end else begin
                    s_d.phase = PH_DONE;
                    if (!s_q.wr) s_d.rdata = mem_dq_in;
                end
            end
            PH_DONE:  s_d.phase = PH_IDLE;
            default:  s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready  = (s_q.phase == PH_IDLE);
    assign done       = (s_q.phase == PH_DONE);
    assign rdata      = s_q.rdata;
    assign mem_addr   = s_q.addr;
    assign mem_dq_out = dq_addr ? DATA_W'(s_q.addr) : s_q.wdata;
endmodule

// File: rtl/amseq_checker.sv
module amseq_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic mem_cs_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_adv_n,
    input logic mem_dq_oe
);
    p_adv_in_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |-> (!mem_cs_n && mem_oe_n && mem_we_n));

    p_oe_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_oe && mem_we_n && !mem_cs_n));

    p_we_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && !mem_cs_n));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mem_cs_n && !req_ready));

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (!mem_cs_n && !mem_adv_n));

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n |-> !req_ready);
endmodule

bind amseq_top amseq_checker u_amseq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_adv_n (mem_adv_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/amseq_top_bench.sv
module amseq_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        mux_en = 1'b1;
    logic        sync_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, done;
    logic [15:0] rdata;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
    logic [15:0] mem_addr, mem_dq_out;
    logic [15:0] mem_dq_in = '0;

    int checks = 0;
    int errors = 0;
    int n_cs, n_adv, n_oe, n_we, abad, wbad, busybad;
    logic [15:0] rd_got;
    logic        done_next, cs_after;

    always #5 clk = ~clk;

    amseq_top u_amseq_top (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One access; optional register write plus stray request during it.
    task automatic run(input bit wr, input logic [15:0] a, input logic [15:0] wd,
                       input logic [15:0] rbase, input bit mid, input logic [15:0] midv);
        int it;
        n_cs = 0; n_adv = 0; n_oe = 0; n_we = 0; abad = 0; wbad = 0; busybad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        mem_dq_in = rbase;
        @(negedge clk);
        req_valid = 1'b0;
        it = 0;
        while (!done && it < 3000) begin
            if (req_ready) busybad++;
            if (!mem_cs_n) n_cs++;
            if (!mem_adv_n) begin
                n_adv++;
                if (mux_en && (mem_dq_out != a || !mem_dq_oe)) abad++;
                if (mem_addr != a) abad++;
            end
            if (!mem_oe_n) begin
                n_oe++;
                mem_dq_in = rbase + 16'(n_oe);
            end
            if (!mem_we_n) begin
                n_we++;
                if (mem_dq_out != wd || !mem_dq_oe) wbad++;
            end
            if (mid && it == 1) begin
                cfg_we = 1'b1; cfg_wdata = midv;
                req_valid = 1'b1; req_addr = ~a;
            end else if (mid && it == 2) begin
                cfg_we = 1'b0; req_valid = 1'b0;
            end
            it++;
            @(negedge clk);
        end
        rd_got = rdata;
        @(negedge clk);
        done_next = done;
        cs_after  = mem_cs_n;
        @(negedge clk);
        cs_after  = cs_after & mem_cs_n;
    endtask

    function automatic int fix(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 cfg reset", int'(cfg_rdata), 16'hFFFF);
        chk("R1 strobes idle", int'({mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n}), 4'hF);
        chk("R1 done low", int'(done), 0);
        chk("R1 ready", int'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after release", int'(req_ready), 1);

        // R1/R5: default timing, longest phases
        run(1'b0, 16'h1234, 16'h0, 16'h0100, 1'b0, 16'h0);
        chk("R1 R2 default setup", n_adv, 16);
        chk("R1 R3 default hold", n_cs - n_adv - n_oe, 16);
        chk("R1 R5 default data", n_oe, 256);
        chk("R6 default read capture", int'(rd_got), 16'h0100 + 256);

        // R2: sweep setup field, multiplexed
        for (int s = 0; s < 16; s++) begin
            set_cfg({8'd2, 4'd3, 4'(s)});
            run(1'b0, 16'(16'hA000 + s), 16'h0, 16'h2000, 1'b0, 16'h0);
            chk("R2 setup length", n_adv, s + 1);
            chk("R2 cs span", n_cs, (s + 1) + 4 + 3);
            chk("R3 address on bus", abad, 0);
        end

        // R3: sweep hold field, multiplexed
        for (int h = 0; h < 16; h++) begin
            set_cfg({8'd1, 4'(h), 4'd1});
            run(1'b1, 16'h00F0, 16'(16'h5500 + h), 16'h0, 1'b0, 16'h0);
            chk("R3 hold length", n_cs - n_adv - n_we, fix(h) + 1);
            chk("R7 write data driven", wbad, 0);
            chk("R7 we length", n_we, 2);
        end

        // R4: non-multiplexed skips hold
        mux_en = 1'b0;
        for (int h = 0; h < 16; h += 5) begin
            set_cfg({8'd3, 4'(h), 4'd2});
            run(1'b0, 16'h0BEE, 16'h0, 16'h3000, 1'b0, 16'h0);
            chk("R4 no hold", n_cs - n_adv - n_oe, 0);
            chk("R4 setup", n_adv, 3);
            chk("R4 address bus", abad, 0);
        end
        mux_en = 1'b1;

        // R5/R6/R7: sweep data field, reads and writes
        for (int d = 0; d < 21; d++) begin
            set_cfg({8'(d), 4'd1, 4'd0});
            run(1'b0, 16'h0042, 16'h0, 16'(16'h4000 + 16 * d), 1'b0, 16'h0);
            chk("R5 read data length", n_oe, fix(d) + 1);
            chk("R6 no we on read", n_we, 0);
            chk("R6 capture last cycle", int'(rd_got), 16'h4000 + 16 * d + fix(d) + 1);
            chk("R8 done one cycle", int'(done_next), 0);
            run(1'b1, 16'h0043, 16'(16'hC000 + d), 16'h0, 1'b0, 16'h0);
            chk("R5 write data length", n_we, fix(d) + 1);
            chk("R7 no oe on write", n_oe, 0);
            chk("R7 bus holds write data", wbad, 0);
            chk("R6 rdata kept over write", int'(rdata), 16'h4000 + 16 * d + fix(d) + 1);
        end
        set_cfg({8'd255, 4'd2, 4'd0});
        run(1'b1, 16'h0001, 16'hBEEF, 16'h0, 1'b0, 16'h0);
        chk("R5 max data length", n_we, 256);

        // R8/R9: register write and stray request mid-access
        set_cfg({8'd6, 4'd4, 4'd5});
        run(1'b0, 16'h7777, 16'h0, 16'h6000, 1'b1, {8'd2, 4'd2, 4'd1});
        chk("R9 setup kept", n_adv, 6);
        chk("R9 hold kept", n_cs - n_adv - n_oe, 5);
        chk("R9 data kept", n_oe, 7);
        chk("R8 ready low while busy", busybad, 0);
        chk("R8 stray request not taken", int'(cs_after), 1);
        chk("R9 new value stored", int'(cfg_rdata), 16'h0221);
        run(1'b0, 16'h7778, 16'h0, 16'h6000, 1'b0, 16'h0);
        chk("R9 next access setup", n_adv, 2);
        chk("R9 next access hold", n_cs - n_adv - n_oe, 3);
        chk("R9 next access data", n_oe, 3);

        // R10: synchronous mode ignores fields
        sync_mode = 1'b1;
        set_cfg(16'hFFFF);
        run(1'b0, 16'h0010, 16'h0, 16'h0, 1'b0, 16'h0);
        chk("R10 sync setup", n_adv, 1);
        chk("R10 sync hold", n_cs - n_adv - n_oe, 2);
        chk("R10 sync data", n_oe, 2);
        set_cfg(16'h0000);
        mux_en = 1'b0;
        run(1'b1, 16'h0011, 16'h1111, 16'h0, 1'b0, 16'h0);
        chk("R10 sync nonmux span", n_cs, 3);
        chk("R10 sync write", n_we, 2);
        sync_mode = 1'b0;
        mux_en = 1'b1;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule